// File: doc/BRIEF.md
# Paged Register Address Unit

This block turns the short register address carried by a serial read or write command into a wider internal register address. Each command carries a 5-bit short address. The block keeps a 7-bit page value and places it above the short address, which gives a 12-bit internal address across 128 pages of 32 registers each.

One short address, the top one (31), is reserved as the page selector. A write to it loads the page value from the low 7 bits of the command's write data. This works whatever page is currently selected. The write never reaches the register bank. The page value cannot be read back: a read of the selector returns zero and touches nothing.

Bank accesses come out one cycle after the command strobe. Each access carries the internal address, a single-cycle write or read strobe, and the write data. Read data from the bank passes back through the block.

Top module: `paged_addr_unit`

## Requirements
- R1: After reset the page value is 0, and both `reg_wr` and `reg_rd` are low until a command arrives.
- R2: On the cycle after `cmd_valid` is sampled high, `reg_addr` equals {page, `cmd_addr`}, with the page in bits 11:5 and the short address in bits 4:0. `reg_addr` holds its value while no command is presented.
- R3: A write command (`cmd_write`=1) to any short address other than 31 raises `reg_wr` for exactly the following cycle, with `reg_wdata` equal to the command's data.
- R4: A read command (`cmd_write`=0) to any short address other than 31 raises `reg_rd` for exactly the following cycle.
- R5: A write to short address 31 loads the page from `cmd_wdata[6:0]` and raises neither `reg_wr` nor `reg_rd`.
- R6: A write to address 31 is accepted whatever page is selected, including page 127.
- R7: A read of address 31 raises no strobe and leaves the page unchanged, and `cmd_rdata` is zero in the following cycle.
- R8: A new page value applies to the command that directly follows the page write, even with no idle cycle between them.
- R9: Bits 23:7 of the write data of a page write have no effect on the page.
- R10: A cycle with `cmd_valid` low raises no strobe and changes neither the page nor `reg_addr`. Outside a selector read, `cmd_rdata` equals `bank_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 5 | Short register address |
| cmd_wdata | input | 24 | Command write data |
| bank_rdata | input | 24 | Read data from the register bank |
| reg_addr | output | 12 | Internal register address {page, short} |
| reg_wr | output | 1 | Bank write strobe |
| reg_rd | output | 1 | Bank read strobe |
| reg_wdata | output | 24 | Bank write data |
| cmd_rdata | output | 24 | Read data returned to the command side |

## Verification
The bench sends a page write followed at once by a bank write. A design that applied the page one command late would put that access on the old page. It writes the selector while page 127 is active, and a design that decoded the selector only on page 0 would ignore the write. It sets the high data bits of page writes and reads the selector between bank accesses. These catch a page taken from the wrong bits, a bank strobe leaking on selector access, a page disturbed by a read, and nonzero data returned from the selector. Random traffic weighted toward address 31 then checks every strobe, address and data word against a bench model.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  localparam int unsigned PGX_SHORT_W = 5;
  localparam int unsigned PGX_PAGE_W  = 7;
  localparam int unsigned PGX_DATA_W  = 24;
endpackage

// File: rtl/pgx_rst_sync.sv
module pgx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/pgx_page_reg.sv
module pgx_page_reg #(
  parameter int unsigned SHORT_W = pgx_pkg::PGX_SHORT_W,
  parameter int unsigned PAGE_W  = pgx_pkg::PGX_PAGE_W,
  parameter int unsigned DATA_W  = pgx_pkg::PGX_DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic               cmd_write,
  input  logic [SHORT_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0]  cmd_wdata,
  output logic               sel_hit,
  output logic [PAGE_W-1:0]  page_q
);
  localparam logic [SHORT_W-1:0] SEL_ADDR = {SHORT_W{1'b1}};

  logic              page_en;
  logic [PAGE_W-1:0] page_d;

  always_comb begin
    sel_hit = cmd_valid && (cmd_addr == SEL_ADDR);
    page_en = sel_hit && cmd_write;
    page_d  = cmd_wdata[PAGE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       page_q <= '0;
    else if (page_en) page_q <= page_d;
  end

  AST_PAGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_write && cmd_addr == SEL_ADDR) |=> page_q == $past(cmd_wdata[PAGE_W-1:0])); // R5
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_write && cmd_addr == SEL_ADDR) |=> $stable(page_q)); // R7
endmodule

// File: rtl/pgx_cmd_stage.sv
module pgx_cmd_stage #(
  parameter int unsigned SHORT_W = pgx_pkg::PGX_SHORT_W,
  parameter int unsigned PAGE_W  = pgx_pkg::PGX_PAGE_W,
  parameter int unsigned DATA_W  = pgx_pkg::PGX_DATA_W,
  localparam int unsigned ADDR_W = SHORT_W + PAGE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic               cmd_write,
  input  logic [SHORT_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0]  cmd_wdata,
  input  logic               sel_hit,
  input  logic [PAGE_W-1:0]  page_q,
  input  logic [DATA_W-1:0]  bank_rdata,
  output logic [ADDR_W-1:0]  reg_addr,
  output logic               reg_wr,
  output logic               reg_rd,
  output logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  cmd_rdata
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic              wr_q, wr_d, rd_q, rd_d, selrd_q, selrd_d;
  logic              addr_en, wdata_en;

  always_comb begin
    addr_en  = cmd_valid;
    addr_d   = {page_q, cmd_addr};
    wr_d     = cmd_valid && cmd_write && !sel_hit;
    rd_d     = cmd_valid && !cmd_write && !sel_hit;
    selrd_d  = sel_hit && !cmd_write;
    wdata_en = wr_d;
    wdata_d  = cmd_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      selrd_q <= 1'b0;
    end else begin
      if (addr_en)  addr_q  <= addr_d;
      if (wdata_en) wdata_q <= wdata_d;
      wr_q    <= wr_d;
      rd_q    <= rd_d;
      selrd_q <= selrd_d;
    end
  end

  always_comb begin
    reg_addr  = addr_q;
    reg_wr    = wr_q;
    reg_rd    = rd_q;
    reg_wdata = wdata_q;
    cmd_rdata = selrd_q ? '0 : bank_rdata;
  end

  AST_SEL_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_addr == {SHORT_W{1'b1}}) |=> (!reg_wr && !reg_rd)); // R5
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_write && cmd_addr != {SHORT_W{1'b1}}) |=> (reg_wr && reg_wdata == $past(cmd_wdata))); // R3
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_write && cmd_addr != {SHORT_W{1'b1}}) |=> reg_rd); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> (!reg_wr && !reg_rd && $stable(reg_addr))); // R10
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_wr, reg_rd})); // R10
endmodule

// File: rtl/paged_addr_unit.sv
module paged_addr_unit #(
  parameter int unsigned SHORT_W = pgx_pkg::PGX_SHORT_W,
  parameter int unsigned PAGE_W  = pgx_pkg::PGX_PAGE_W,
  parameter int unsigned DATA_W  = pgx_pkg::PGX_DATA_W,
  localparam int unsigned ADDR_W = SHORT_W + PAGE_W
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               cmd_valid,
  input  logic               cmd_write,
  input  logic [SHORT_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0]  cmd_wdata,
  input  logic [DATA_W-1:0]  bank_rdata,
  output logic [ADDR_W-1:0]  reg_addr,
  output logic               reg_wr,
  output logic               reg_rd,
  output logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  cmd_rdata
);
  logic              rst_n;
  logic              sel_hit;
  logic [PAGE_W-1:0] page_q;

  pgx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_ni(rst_ni), .rst_no(rst_n)
  );

  pgx_page_reg #(.SHORT_W(SHORT_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_page (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .sel_hit(sel_hit), .page_q(page_q)
  );

  pgx_cmd_stage #(.SHORT_W(SHORT_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .sel_hit(sel_hit), .page_q(page_q),
    .bank_rdata(bank_rdata), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .cmd_rdata(cmd_rdata)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(rst_n) |-> (!reg_wr && !reg_rd && page_q == '0)); // R1
endmodule

// File: tb/paged_addr_unit_bench.sv
module paged_addr_unit_bench;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        cmd_valid, cmd_write;
  logic [4:0]  cmd_addr;
  logic [23:0] cmd_wdata, bank_rdata;
  logic [11:0] reg_addr;
  logic        reg_wr, reg_rd;
  logic [23:0] reg_wdata, cmd_rdata;

  int total = 0;
  int bad   = 0;

  logic [6:0]  page_m;
  logic [11:0] e_addr;
  logic        e_wr, e_rd, e_selrd, have_addr;
  logic [23:0] e_wd;

  always #4 clk = ~clk;

  paged_addr_unit u_paged_addr_unit (
    .clk(clk), .rst_ni(rst_ni), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .bank_rdata(bank_rdata),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .cmd_rdata(cmd_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_addr(input logic [6:0] pg, input logic [4:0] a);
    return {pg, a};
  endfunction

  task automatic check_out();
    chk("R3/R5 reg_wr", {31'd0, reg_wr}, {31'd0, e_wr});
    chk("R4/R7 reg_rd", {31'd0, reg_rd}, {31'd0, e_rd});
    if (have_addr) chk("R2/R8 reg_addr", {20'd0, reg_addr}, {20'd0, e_addr});
    if (e_wr) chk("R3 reg_wdata", {8'd0, reg_wdata}, {8'd0, e_wd});
    chk("R7/R10 cmd_rdata", {8'd0, cmd_rdata}, {8'd0, (e_selrd ? 24'd0 : bank_rdata)});
  endtask

  task automatic cmd(input logic v, input logic w, input logic [4:0] a, input logic [23:0] d);
    @(negedge clk);
    check_out();
    cmd_valid  = v;
    cmd_write  = w;
    cmd_addr   = a;
    cmd_wdata  = d;
    bank_rdata = 24'($urandom());
    e_selrd = v && !w && (a == 5'd31);
    if (v) begin
      e_addr    = exp_addr(page_m, a);
      have_addr = 1'b1;
      e_wr = w && (a != 5'd31);
      e_rd = !w && (a != 5'd31);
      if (e_wr) e_wd = d;
      if (w && a == 5'd31) page_m = d[6:0];
    end else begin
      e_wr = 1'b0;
      e_rd = 1'b0;
    end
  endtask

  initial begin
    #(8 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rst_ni = 1'b0; cmd_valid = 1'b0; cmd_write = 1'b0; cmd_addr = '0;
    cmd_wdata = '0; bank_rdata = 24'h00ABCD;
    page_m = '0; e_addr = '0; e_wr = 0; e_rd = 0; e_selrd = 0; e_wd = '0; have_addr = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    // R1: strobes quiet after reset, page 0 seen by first access
    chk("R1 reg_wr", {31'd0, reg_wr}, 32'd0);
    chk("R1 reg_rd", {31'd0, reg_rd}, 32'd0);
    cmd(1, 0, 5'd3, 24'd0);
    cmd(0, 0, 5'd0, 24'd0);
    chk("R1 page zero", {20'd0, reg_addr}, 32'h003);
    // R8: page write then bank write back to back
    cmd(1, 1, 5'd31, 24'h000005);
    cmd(1, 1, 5'd7, 24'h123456);
    cmd(0, 0, 5'd0, 24'd0);
    chk("R8 back-to-back", {20'd0, reg_addr}, 32'h0A7);
    // R6: selector write accepted while on page 127
    cmd(1, 1, 5'd31, 24'h00007F);
    cmd(1, 1, 5'd31, 24'h000002);
    cmd(1, 0, 5'd0, 24'd0);
    cmd(0, 0, 5'd0, 24'd0);
    chk("R6 from page 127", {20'd0, reg_addr}, 32'h040);
    // R9: high data bits ignored by the page
    cmd(1, 1, 5'd31, 24'hFFFF83);
    cmd(1, 0, 5'd1, 24'd0);
    cmd(0, 0, 5'd0, 24'd0);
    chk("R9 high bits", {20'd0, reg_addr}, 32'h061);
    // R7: selector read returns zero and keeps the page
    cmd(1, 0, 5'd31, 24'd0);
    cmd(1, 0, 5'd2, 24'd0);
    cmd(0, 0, 5'd0, 24'd0);
    chk("R7 page kept", {20'd0, reg_addr}, 32'h062);
    // random traffic, biased toward the selector
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] a;
      a = ($urandom_range(0, 3) == 0) ? 5'd31 : 5'($urandom());
      cmd(1'($urandom_range(0, 3) != 0), 1'($urandom()), a, 24'($urandom()));
    end
    cmd(0, 0, 5'd0, 24'd0);
    @(negedge clk);
    check_out();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule